// File: doc/BRIEF.md
# Turnaround-free pipelined synchronous SRAM

A single-clock synchronous static memory whose command interface never needs an idle cycle between a read and a write. The address, the control inputs and the write data are all captured on the rising clock edge. Each access is a fixed two-edge pipeline. A read returns its word on the output register after the second enabled edge. A write expects its data on the second enabled edge after its address. Because both directions use the same bus slot two edges after the command, reads and writes can be mixed freely and the data bus stays busy every cycle.

The storage is split into 9-bit lanes, and each lane has its own active-low write enable. Three select inputs must agree on a load cycle for the access to take place. A deselected load leaves an empty slot on the bus. A load/advance input either starts a new access or steps a 2-bit burst counter, so a burst reaches four words without new addresses. The counter runs in linear or interleaved order. An active-low clock enable freezes the whole pipeline, output register included. An asynchronous output enable gates the bus drive, and the tristate pad is brought out as a data port plus a drive-enable port.

Top module: `tsram_top`

## Requirements
- R1: A read loaded on enabled edge k (loadN=0, rdWrN=1, selected) presents the stored word on rdata after enabled edge k+2, with rdataOe high while outEnN is low.
- R2: A write loaded on enabled edge k takes its data from wdata at enabled edge k+2. Lane l is bits [9l+8:9l] and is written only when laneWrN[l]=0 on the load (or advance) edge. A lane that is not enabled keeps its previous content.
- R3: While clkEnN is high, clock edges are ignored: the pipeline, the burst counter, rdata and rdataOe all hold their values.
- R4: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and a read always returns the newest data, including bytes written by the write loaded one edge earlier.
- R5: An access is selected only when selLoN=0, selHi=1 and selAltN=0 on the load edge. A deselected load performs no write, and rdataOe stays low in its output slot.
- R6: With burstMode=0 (linear), each advance edge (loadN=1) accesses the loaded address with its low 2 bits replaced by (base+n) mod 4, for n=1,2,3,0, and the upper bits unchanged.
- R7: With burstMode=1 (interleaved), the n-th advance accesses the loaded address with its low 2 bits replaced by base XOR n.
- R8: Advance edges keep the read/write type captured at the load, and rdWrN is ignored on them.
- R9: Advance edges that follow a deselected load perform no access, and the burst counter does not move.
- R10: outEnN acts combinationally: when it is high, rdataOe is low without any clock edge, and rdata keeps its value.
- R11: During and right after reset, rdataOe is low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high freezes all state |
| loadN | input | 1 | Low: load a new access; high: advance the burst |
| rdWrN | input | 1 | Cycle type on load: 1 read, 0 write |
| selLoN | input | 1 | Active-low select, sampled on load |
| selHi | input | 1 | Active-high select, sampled on load |
| selAltN | input | 1 | Second active-low select, sampled on load |
| burstMode | input | 1 | 0 linear order, 1 interleaved order |
| addr | input | ADDR_W | Word address, sampled on load |
| laneWrN | input | LANES | Active-low per-lane write enables |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after the address |
| outEnN | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Output register contents |
| rdataOe | output | 1 | Bus drive enable for rdata |

## Verification
The in-module assertions check on every cycle that a high clock enable freezes the pipeline and the output register. They also check that linear advance steps the low address bits by one, that a deselected burst leaves its counter still, that a read command always produces a valid output slot, and that bytes pending in the write stage are forwarded into a read of the same address. Only the bench scenarios can show the end-to-end data behaviour. These cover the two-edge read and write alignment, partial lane writes, interleaved burst order, type retention in bursts, and the effect of each select input. They also show that freeze cycles inserted mid-stream do not disturb results, and that the output enable gates the bus without a clock.

// File: rtl/tsram_pkg.sv
package tsram_pkg;

  // Strobes from control to datapath, valid for the current clock edge.
  typedef struct packed {
    logic advance;       // edge is enabled: every register may move
    logic captureWrite;  // access in stage 2 is a write: capture wdata now
    logic loadRead;      // access in stage 2 is a read: load output register
  } dpStrobe_t;

  typedef enum logic {
    BURST_LINEAR      = 1'b0,
    BURST_INTERLEAVED = 1'b1
  } burstOrder_t;

endpackage

// File: rtl/tsram_ctrl.sv
module tsram_ctrl
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,   // must be at least 3
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              loadN,
  input  logic              rdWrN,
  input  logic              selLoN,
  input  logic              selHi,
  input  logic              selAltN,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  laneWrN,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [LANES-1:0]  opBe
);

  localparam int UPPER_W = ADDR_W - 2;

  logic              selNow;
  logic              burstSel, burstWr;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt, stepCnt, lowNext;
  logic [ADDR_W-1:0] nextAddr;

  logic              s1Valid, s1Write, s2Valid, s2Write;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Be, s2Be;

  assign selNow  = !selLoN && selHi && !selAltN;
  assign stepCnt = cnt + 2'd1;

  always_comb begin
    if (burstOrder_t'(burstMode) == BURST_INTERLEAVED)
      lowNext = base[1:0] ^ stepCnt;
    else
      lowNext = base[1:0] + stepCnt;
  end

  assign nextAddr = {base[ADDR_W-1 -: UPPER_W], lowNext};

  // Burst state and stage 1: the access chosen on this edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstSel <= 1'b0;
      burstWr  <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      s1Valid  <= 1'b0;
      s1Write  <= 1'b0;
      s1Addr   <= '0;
      s1Be     <= '0;
    end else if (!clkEnN) begin
      s1Be <= ~laneWrN;
      if (!loadN) begin
        burstSel <= selNow;
        burstWr  <= !rdWrN;
        base     <= addr;
        cnt      <= '0;
        s1Valid  <= selNow;
        s1Write  <= !rdWrN;
        s1Addr   <= addr;
      end else begin
        if (burstSel) cnt <= stepCnt;
        s1Valid <= burstSel;
        s1Write <= burstWr;
        s1Addr  <= nextAddr;
      end
    end
  end

  // Stage 2: address and lanes presented to the datapath.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
      s2Be    <= '0;
    end else if (!clkEnN) begin
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
      s2Be    <= s1Be;
    end
  end

  assign strobe.advance      = !clkEnN;
  assign strobe.captureWrite = s2Valid && s2Write;
  assign strobe.loadRead     = s2Valid && !s2Write;
  assign opAddr              = s2Addr;
  assign opBe                = s2Be;

  AST_FREEZE_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(s1Addr) && $stable(s1Valid) && $stable(s2Addr) &&
                $stable(s2Valid) && $stable(cnt))); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN && burstSel && !burstMode) |=>
      ((s1Addr[1:0] == $past(s1Addr[1:0]) + 2'd1) &&
       (s1Addr[ADDR_W-1:2] == $past(s1Addr[ADDR_W-1:2])))); // R6

  AST_DESEL_BURST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN && !burstSel) |=> ($stable(cnt) && !s1Valid)); // R9

endmodule

// File: rtl/tsram_datapath.sv
module tsram_datapath
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        opBe,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdataOe
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // Stage 3: write waiting for its array update.
  logic              wrPend;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrBe;
  logic [DATA_W-1:0] wrData;

  logic              addrHit;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] dout;
  logic              outValid;

  assign addrHit = wrPend && (wrAddr == opAddr);

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.advance && wrPend && wrBe[l])
        laneMem[wrAddr] <= wrData[l*LANE_W +: LANE_W];
    end

    assign merged[l*LANE_W +: LANE_W] = (addrHit && wrBe[l]) ?
      wrData[l*LANE_W +: LANE_W] : laneMem[opAddr];

    AST_FWD_LANE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.advance && strobe.loadRead && wrPend && (wrAddr == opAddr) && wrBe[l])
        |=> (dout[l*LANE_W +: LANE_W] == $past(wrData[l*LANE_W +: LANE_W]))); // R4
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend   <= 1'b0;
      wrAddr   <= '0;
      wrBe     <= '0;
      wrData   <= '0;
      outValid <= 1'b0;
      dout     <= '0;
    end else if (strobe.advance) begin
      wrPend <= strobe.captureWrite;
      if (strobe.captureWrite) begin
        wrAddr <= opAddr;
        wrBe   <= opBe;
        wrData <= wdata;
      end
      outValid <= strobe.loadRead;
      if (strobe.loadRead) dout <= merged;
    end
  end

  assign rdata   = dout;
  assign rdataOe = outValid && !outEnN;

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(dout) && $stable(outValid) && $stable(wrPend))); // R3

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.loadRead) |=> outValid); // R1

endmodule

// File: rtl/tsram_top.sv
module tsram_top
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    loadN,
  input  logic                    rdWrN,
  input  logic                    selLoN,
  input  logic                    selHi,
  input  logic                    selAltN,
  input  logic                    burstMode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        laneWrN,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdataOe
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [LANES-1:0]  opBe;

  tsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .rdWrN(rdWrN),
    .selLoN(selLoN), .selHi(selHi), .selAltN(selAltN), .burstMode(burstMode),
    .addr(addr), .laneWrN(laneWrN), .strobe(strobe), .opAddr(opAddr), .opBe(opBe)
  );

  tsram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opAddr(opAddr), .opBe(opBe),
    .outEnN(outEnN), .wdata(wdata), .rdata(rdata), .rdataOe(rdataOe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !rdataOe); // R11

endmodule

// File: tb/tb_tsram_top.sv
module tb_tsram_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0;
  logic rstN, clkEnN, loadN, rdWrN, selLoN, selHi, selAltN, burstMode, outEnN;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  laneWrN;
  logic [DATA_W-1:0] wdata, rdata;
  logic              rdataOe;

  always #(CLK_P/2) clk = ~clk;

  tsram_top #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .rdWrN(rdWrN),
    .selLoN(selLoN), .selHi(selHi), .selAltN(selAltN), .burstMode(burstMode),
    .addr(addr), .laneWrN(laneWrN), .wdata(wdata), .outEnN(outEnN),
    .rdata(rdata), .rdataOe(rdataOe)
  );

  typedef struct {
    int                due;
    logic [DATA_W-1:0] data;
    string             tag;
  } expItem_t;

  expItem_t          expQ[$];
  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] wSched [int];
  int  checks = 0;
  int  errors = 0;
  int  drvEdge = 0;
  int  monEdge = 0;
  bit  finished = 0;
  string curTag = "R1";

  // bench burst model
  logic [ADDR_W-1:0] bBase = '0;
  logic [1:0]        bCnt = '0;
  bit                bSel = 0;
  bit                bWr = 0;

  localparam logic [2:0] SEL_OK = 3'b010;  // {selLoN, selHi, selAltN}

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int a, input int salt);
    logic [DATA_W-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*LANE_W +: LANE_W] = LANE_W'(a * 5 + l * 77 + salt);
    return v;
  endfunction

  // One clock cycle of stimulus; returns at the following falling edge.
  task automatic step(input bit hold, input bit ld, input bit rd, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] be, input logic [DATA_W-1:0] wd,
                      input logic [2:0] sel);
    bit opV, opW;
    logic [ADDR_W-1:0] opA;
    logic [1:0] low;
    int idx;
    opV = 0; opW = 0; opA = a;
    if (!hold) begin
      drvEdge++;
      if (ld) begin
        bBase = a; bCnt = 0; bSel = (sel == SEL_OK); bWr = !rd;
        opV = bSel; opW = !rd;
      end else if (bSel) begin
        bCnt = bCnt + 2'd1;
        low  = burstMode ? (bBase[1:0] ^ bCnt) : (bBase[1:0] + bCnt);
        opA  = {bBase[ADDR_W-1:2], low};
        opV  = 1; opW = bWr;
      end
      if (opV && opW) begin
        for (int l = 0; l < LANES; l++)
          if (be[l]) refMem[opA][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
        wSched[drvEdge + 2] = wd;
      end else if (opV) begin
        expQ.push_back('{drvEdge + 2, refMem[opA], curTag});
      end
    end
    idx = hold ? drvEdge + 1 : drvEdge;
    clkEnN  = hold;
    loadN   = !ld;
    rdWrN   = rd;
    addr    = a;
    laneWrN = ~be;
    {selLoN, selHi, selAltN} = sel;
    wdata   = wSched.exists(idx) ? wSched[idx] : '0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
    step(0, 1, 0, ADDR_W'(a), be, d, SEL_OK);
  endtask

  task automatic rd(input int a);
    step(0, 1, 1, ADDR_W'(a), '0, '0, SEL_OK);
  endtask

  task automatic idle();
    step(0, 1, 1, '0, '0, '0, 3'b110);
  endtask

  task automatic adv(input bit rdIn, input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
    step(0, 0, rdIn, '0, be, d, SEL_OK);
  endtask

  // Scoreboard monitor: one look per clock, a quarter period after the edge.
  initial begin
    logic [DATA_W-1:0] prevD;
    logic prevOe;
    bit en, frz;
    expItem_t e;
    prevD = '0; prevOe = 0;
    forever begin
      @(posedge clk);
      en  = rstN && !clkEnN;
      frz = rstN && clkEnN;
      #(CLK_P/4);
      if (en) begin
        monEdge++;
        if (expQ.size() > 0 && expQ[0].due == monEdge) begin
          e = expQ.pop_front();
          check(rdata === e.data, e.tag, "read data", rdata, e.data);
          check(rdataOe === !outEnN, e.tag, "read drive enable", DATA_W'(rdataOe), DATA_W'(!outEnN));
        end else begin
          check(rdataOe === 1'b0, "R5", "empty slot drives bus", DATA_W'(rdataOe), '0);
        end
      end else if (frz) begin
        check(rdata === prevD && rdataOe === prevOe, "R3", "output moved while frozen",
              rdata, prevD);
      end
      prevD = rdata; prevOe = rdataOe;
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", monEdge, drvEdge);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; clkEnN = 0; loadN = 1; rdWrN = 1; selLoN = 1; selHi = 0; selAltN = 1;
    burstMode = 0; outEnN = 0; addr = '0; laneWrN = '1; wdata = '0;
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    check(rdataOe === 1'b0, "R11", "drive enable in reset", DATA_W'(rdataOe), '0);
    rstN = 1;

    // R2: fill every word with full-lane writes
    curTag = "R2";
    for (int i = 0; i < DEPTH; i++) wr(i, 4'hF, pattern(i, 1));
    idle(); idle();

    // R1: plain reads, back to back
    curTag = "R1";
    rd(3); rd(40); rd(63); rd(0);
    idle(); idle();

    // R2: partial lane write leaves other lanes untouched
    curTag = "R2";
    wr(5, 4'b0101, pattern(5, 200));
    wr(6, 4'b1000, pattern(6, 300));
    idle(); idle();
    rd(5); rd(6);
    idle(); idle();

    // R4: alternating write/read to the same words, no gaps
    curTag = "R4";
    wr(10, 4'hF, pattern(10, 400)); rd(10);
    wr(11, 4'b0011, pattern(11, 500)); rd(11);
    rd(10); wr(10, 4'b1100, pattern(10, 600)); rd(10); rd(11);
    idle(); idle();

    // R3: freeze cycles inserted in the middle of a read/write stream
    curTag = "R3";
    wr(12, 4'hF, pattern(12, 700));
    step(1, 1, 1, 6'd60, '0, '0, SEL_OK);
    step(1, 0, 0, 6'd61, 4'hF, pattern(61, 1), SEL_OK);
    rd(12);
    step(1, 1, 0, 6'd62, 4'hF, '0, SEL_OK);
    step(1, 1, 0, 6'd62, 4'hF, '0, SEL_OK);
    rd(13); idle();
    step(1, 1, 1, '0, '0, '0, 3'b110);
    idle(); idle();

    // R5: each select input alone blocks a write and a read
    curTag = "R5";
    step(0, 1, 0, 6'd20, 4'hF, pattern(20, 800), 3'b110);
    step(0, 1, 0, 6'd21, 4'hF, pattern(21, 800), 3'b000);
    step(0, 1, 0, 6'd22, 4'hF, pattern(22, 800), 3'b011);
    step(0, 1, 1, 6'd23, '0, '0, 3'b011);
    step(0, 1, 1, 6'd23, '0, '0, 3'b000);
    idle(); idle();
    rd(20); rd(21); rd(22);
    idle(); idle();

    // R6: linear burst read from a base with low bits 01
    curTag = "R6";
    burstMode = 0;
    rd(13); adv(1, '0, '0); adv(1, '0, '0); adv(1, '0, '0); adv(1, '0, '0);
    idle(); idle();

    // R7: interleaved burst read from a base with low bits 10
    curTag = "R7";
    burstMode = 1;
    rd(46); adv(1, '0, '0); adv(1, '0, '0); adv(1, '0, '0);
    idle(); idle();

    // R8: burst write keeps its type although rdWrN is high on advance edges
    curTag = "R8";
    burstMode = 0;
    wr(25, 4'hF, pattern(25, 900));
    adv(1, 4'hF, pattern(26, 900)); adv(1, 4'b0001, pattern(27, 900)); adv(1, 4'hF, pattern(24, 900));
    idle(); idle();
    rd(24); adv(1, '0, '0); adv(1, '0, '0); adv(1, '0, '0);
    idle(); idle();

    // R9: advance after a deselected write load does nothing
    curTag = "R9";
    step(0, 1, 0, 6'd30, 4'hF, pattern(30, 1000), 3'b110);
    adv(0, 4'hF, pattern(31, 1000)); adv(1, 4'hF, pattern(32, 1000)); adv(0, 4'hF, pattern(33, 1000));
    idle(); idle();
    rd(28); adv(1, '0, '0); adv(1, '0, '0); adv(1, '0, '0);
    rd(30); rd(31);
    idle(); idle();

    // R10: output enable gates the drive without a clock edge
    curTag = "R10";
    rd(50); idle(); idle();
    outEnN = 1; #1;
    check(rdataOe === 1'b0, "R10", "drive with outEnN high", DATA_W'(rdataOe), '0);
    check(rdata === refMem[50], "R10", "data held with outEnN high", rdata, refMem[50]);
    outEnN = 0; #1;
    check(rdataOe === 1'b1, "R10", "drive after outEnN low", DATA_W'(rdataOe), 1);
    idle(); idle(); idle();

    check(expQ.size() == 0, "R1", "expected reads left over", DATA_W'(expQ.size()), '0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule